// File: doc/BRIEF.md
# Word Splitter and Selective Packer

This block sits between a buffer that holds wide words and a processing engine that accepts one byte per cycle. On its feed side it takes a 40-bit word from the buffer and presents it to the engine as five bytes on five back-to-back cycles. The lowest byte goes first, and a valid strobe accompanies each byte. When the fifth byte is on the port and another word is waiting, the next word is taken in that same cycle, so consecutive words stream with no idle cycle between them.

On its return side the block watches the engine's byte-valid output. It counts valid bytes in groups of five. The first three bytes of each group are assembled into a 24-bit result, and the remaining two are discarded. This suits an engine that emits five bytes per block when only three of them carry payload. A one-cycle result-valid pulse marks each finished result. Invalid cycles between valid bytes are skipped, however long the gap.

Top module: `word_split_pack`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and right after it, `proc_valid`, `pack_valid` and `pack_data` are 0, and `proc_byte` is 0.
- R2: `fifo_pop` is never high while `fifo_empty` is high.
- R3: In the cycle after a `fifo_pop`, and in the four cycles that follow it, `proc_valid` is high and `proc_byte` carries bits 7:0, 15:8, 23:16, 31:24 and 39:32 of the popped word, in that order.
- R4: `proc_valid` is low whenever no word is being serialized, and `proc_byte` is 0 in any cycle where `proc_valid` is low.
- R5: A pop happens only when the serializer is idle or is presenting the fifth byte. A pop during the fifth byte makes the next word's first byte follow with no gap.
- R6: The first three cycles of a group in which `proc_out_valid` is high put `proc_out_byte` into `pack_data` bits 7:0, 15:8 and 23:16 respectively.
- R7: `pack_data` changes only in a cycle where `pack_valid` is high. The fourth and fifth valid bytes of a group, and any byte offered while `proc_out_valid` is low, leave it unchanged.
- R8: `pack_valid` is a one-cycle pulse. It is high in the cycle after the clock edge that takes in the third valid byte of a group, and low at all other times.
- R9: The group position advances only on edges where `proc_out_valid` is high, and it wraps to the first position after the fifth valid byte.
- R10: A reset in the middle of a word or a group discards the partial work. After reset the next valid byte is the first of a new group, and the next popped word starts at its lowest byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Buffer holds no word |
| fifo_word | input | 40 | Word at the head of the buffer (show-ahead) |
| fifo_pop | output | 1 | Takes the head word this cycle |
| proc_byte | output | 8 | Byte presented to the engine |
| proc_valid | output | 1 | `proc_byte` is valid |
| proc_out_byte | input | 8 | Byte returned by the engine |
| proc_out_valid | input | 1 | `proc_out_byte` is valid |
| pack_data | output | 24 | Assembled result, first kept byte in bits 7:0 |
| pack_valid | output | 1 | One-cycle pulse: `pack_data` holds a new result |

## Verification
A word popped at one edge shows its lowest byte on `proc_byte` from the next edge. Its other four bytes follow on the four edges after that. A result appears with `pack_valid` one edge after the edge that took in the third valid returned byte. The bench updates a reference model at each rising edge from the inputs it applied one nanosecond after the previous edge. It then compares the outputs at the falling edge against the model's expectation for that exact cycle: expected bytes and results wait in queues, and a per-cycle flag says whether a strobe or a pulse is due.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  typedef enum logic {
    SER_IDLE = 1'b0,
    SER_SEND = 1'b1
  } ser_state_e;

  // number of lanes a word splits into
  function automatic int lanes_in(input int word_w, input int lane_w);
    return word_w / lane_w;
  endfunction

  // counter width for a modulus, at least one bit
  function automatic int cnt_width(input int modulus);
    return (modulus > 1) ? $clog2(modulus) : 1;
  endfunction

endpackage

// File: rtl/wsp_mod_counter.sv
module wsp_mod_counter #(
  parameter int MOD = 5,
  localparam int CW = wsp_pkg::cnt_width(MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_top
);

  assign at_top = (count == CW'(MOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc) begin
      count <= at_top ? '0 : count + CW'(1);
    end
  end

endmodule

// File: rtl/wsp_serializer.sv
module wsp_serializer
  import wsp_pkg::*;
#(
  parameter int WORD_W = 40,
  parameter int LANE_W = 8,
  localparam int LANES = lanes_in(WORD_W, LANE_W),
  localparam int IW    = cnt_width(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_empty,
  input  logic [WORD_W-1:0] src_word,
  output logic              src_take,
  output logic [LANE_W-1:0] lane_data,
  output logic              lane_valid,
  output logic              lane_last
);

  ser_state_e        state;
  logic [WORD_W-1:0] hold;
  logic [IW-1:0]     idx;
  logic              idx_top;
  logic              can_take;

  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                 input logic [IW-1:0] i);
    return w[i*LANE_W +: LANE_W];
  endfunction

  wsp_mod_counter #(.MOD(LANES)) lane_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (lane_valid),
    .count  (idx),
    .at_top (idx_top)
  );

  assign lane_valid = (state == SER_SEND);
  assign lane_last  = lane_valid && idx_top;
  assign can_take   = (state == SER_IDLE) || lane_last;
  assign src_take   = can_take && !src_empty;
  assign lane_data  = lane_valid ? lane_of(hold, idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SER_IDLE;
      hold  <= '0;
    end else if (src_take) begin
      state <= SER_SEND;
      hold  <= src_word;
    end else if (lane_last) begin
      state <= SER_IDLE;
    end
  end

endmodule

// File: rtl/wsp_packer.sv
module wsp_packer
  import wsp_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int GROUP_N = 5,
  parameter int KEEP_N  = 3,
  localparam int CW    = cnt_width(GROUP_N),
  localparam int RES_W = LANE_W * KEEP_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] in_byte,
  input  logic              in_valid,
  output logic [RES_W-1:0]  result,
  output logic              result_valid,
  output logic              keep_now,
  output logic              final_now
);

  logic [CW-1:0]    pos;
  logic             pos_top;
  logic [RES_W-1:0] stage;
  logic [RES_W-1:0] merged;

  function automatic logic [RES_W-1:0] place_lane(input logic [RES_W-1:0] acc,
                                                   input logic [CW-1:0] slot,
                                                   input logic [LANE_W-1:0] b);
    logic [RES_W-1:0] r;
    r = acc;
    r[slot*LANE_W +: LANE_W] = b;
    return r;
  endfunction

  wsp_mod_counter #(.MOD(GROUP_N)) group_cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (in_valid),
    .count  (pos),
    .at_top (pos_top)
  );

  assign keep_now  = in_valid && (pos < CW'(KEEP_N));
  assign final_now = in_valid && (pos == CW'(KEEP_N - 1));
  assign merged    = place_lane(stage, pos, in_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= final_now;
      if (keep_now) begin
        stage <= merged;
      end
      if (final_now) begin
        result <= merged;
      end
    end
  end

endmodule

// File: rtl/word_split_pack.sv
module word_split_pack
  import wsp_pkg::*;
#(
  parameter int WORD_W  = 40,
  parameter int LANE_W  = 8,
  parameter int GROUP_N = 5,
  parameter int KEEP_N  = 3,
  localparam int RES_W = LANE_W * KEEP_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_word,
  output logic              fifo_pop,
  output logic [LANE_W-1:0] proc_byte,
  output logic              proc_valid,
  input  logic [LANE_W-1:0] proc_out_byte,
  input  logic              proc_out_valid,
  output logic [RES_W-1:0]  pack_data,
  output logic              pack_valid
);

  // named internal events, observed by the bound checker
  logic ser_last;
  logic pk_keep;
  logic pk_final;

  wsp_serializer #(.WORD_W(WORD_W), .LANE_W(LANE_W)) ser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_empty  (fifo_empty),
    .src_word   (fifo_word),
    .src_take   (fifo_pop),
    .lane_data  (proc_byte),
    .lane_valid (proc_valid),
    .lane_last  (ser_last)
  );

  wsp_packer #(.LANE_W(LANE_W), .GROUP_N(GROUP_N), .KEEP_N(KEEP_N)) pk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_byte      (proc_out_byte),
    .in_valid     (proc_out_valid),
    .result       (pack_data),
    .result_valid (pack_valid),
    .keep_now     (pk_keep),
    .final_now    (pk_final)
  );

endmodule

// File: rtl/wsp_checker.sv
module wsp_checker #(
  parameter int WORD_W = 40,
  parameter int LANE_W = 8,
  parameter int RES_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_empty,
  input logic [WORD_W-1:0] fifo_word,
  input logic              fifo_pop,
  input logic [LANE_W-1:0] proc_byte,
  input logic              proc_valid,
  input logic [LANE_W-1:0] proc_out_byte,
  input logic              pack_valid,
  input logic [RES_W-1:0]  pack_data,
  input logic              ser_last,
  input logic              pk_keep,
  input logic              pk_final
);

  // R2
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R3
  first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (proc_valid && proc_byte == $past(fifo_word[LANE_W-1:0])));

  // R3
  last_lane_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |-> proc_valid);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_valid |-> (proc_byte == '0));

  // R5
  pop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && proc_valid) |-> ser_last);

  // R6
  top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pack_valid |-> (pack_data[RES_W-1 -: LANE_W] == $past(proc_out_byte)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_valid |-> $stable(pack_data));

  // R8
  pulse_after_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_final |=> pack_valid);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pack_valid |=> !pack_valid);

  // R9
  final_is_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_final |-> pk_keep);

endmodule

bind word_split_pack wsp_checker #(
  .WORD_W (WORD_W),
  .LANE_W (LANE_W),
  .RES_W  (RES_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_empty    (fifo_empty),
  .fifo_word     (fifo_word),
  .fifo_pop      (fifo_pop),
  .proc_byte     (proc_byte),
  .proc_valid    (proc_valid),
  .proc_out_byte (proc_out_byte),
  .pack_valid    (pack_valid),
  .pack_data     (pack_data),
  .ser_last      (ser_last),
  .pk_keep       (pk_keep),
  .pk_final      (pk_final)
);

// File: tb/word_split_pack_tb_top.sv
module word_split_pack_tb_top;

  localparam int WW = 40;
  localparam int LW = 8;
  localparam int NL = 5;
  localparam int RW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_empty = 1'b1;
  logic [WW-1:0] fifo_word = '0;
  logic          fifo_pop;
  logic [LW-1:0] proc_byte;
  logic          proc_valid;
  logic [LW-1:0] proc_out_byte = '0;
  logic          proc_out_valid = 1'b0;
  logic [RW-1:0] pack_data;
  logic          pack_valid;

  int checks = 0;
  int errors = 0;
  int packs_seen = 0;
  bit finished = 1'b0;

  logic [WW-1:0] src_q[$];
  logic [LW-1:0] exp_lane_q[$];
  logic [RW-1:0] exp_pack_q[$];

  always #2 clk = ~clk;

  word_split_pack dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_empty     (fifo_empty),
    .fifo_word      (fifo_word),
    .fifo_pop       (fifo_pop),
    .proc_byte      (proc_byte),
    .proc_valid     (proc_valid),
    .proc_out_byte  (proc_out_byte),
    .proc_out_valid (proc_out_valid),
    .pack_data      (pack_data),
    .pack_valid     (pack_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard: model update at rising edge, compare at falling edge
  initial begin
    int            rem = 0;
    int            pcnt = 0;
    bit            pulse_due = 1'b0;
    logic [RW-1:0] stage = '0;
    logic [RW-1:0] last_data = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        rem = 0; pcnt = 0; pulse_due = 1'b0; stage = '0;
        exp_lane_q.delete();
        exp_pack_q.delete();
      end else begin
        if (fifo_pop) check(!fifo_empty, "R2 pop while empty", fifo_pop, 0);
        if (fifo_pop) check(rem <= 1, "R5 pop outside window", rem, 1);
        if (rem > 0) rem--;
        if (fifo_pop && src_q.size() > 0) begin
          logic [WW-1:0] w;
          w = src_q.pop_front();
          for (int k = 0; k < NL; k++) exp_lane_q.push_back(w[k*LW +: LW]);
          rem = NL;
        end
        pulse_due = 1'b0;
        if (proc_out_valid) begin
          if (pcnt < 3) stage[pcnt*LW +: LW] = proc_out_byte;
          if (pcnt == 2) begin
            exp_pack_q.push_back(stage);
            pulse_due = 1'b1;
          end
          pcnt = (pcnt == 4) ? 0 : pcnt + 1;
        end
      end
      @(negedge clk);
      if (!rst_n) begin
        last_data = '0;
      end else begin
        check(proc_valid == (rem > 0), "R3/R4 strobe timing", proc_valid, rem > 0);
        if (proc_valid) begin
          if (exp_lane_q.size() > 0) begin
            logic [LW-1:0] eb;
            eb = exp_lane_q.pop_front();
            check(proc_byte == eb, "R3 byte order", proc_byte, eb);
          end else check(1'b0, "R3 unexpected byte", proc_byte, 0);
        end else begin
          check(proc_byte == '0, "R4 idle byte", proc_byte, 0);
        end
        check(pack_valid == pulse_due, "R8 pulse timing", pack_valid, pulse_due);
        if (pack_valid) begin
          packs_seen++;
          if (exp_pack_q.size() > 0) begin
            last_data = exp_pack_q.pop_front();
            check(pack_data == last_data, "R6 packed result", pack_data, last_data);
          end else check(1'b0, "R6 unexpected result", pack_data, 0);
        end else begin
          check(pack_data == last_data, "R7 result held", pack_data, last_data);
        end
      end
      fifo_empty = (src_q.size() == 0);
      fifo_word  = (src_q.size() > 0) ? src_q[0] : '0;
    end
  end

  task automatic push_word(input logic [WW-1:0] w);
    @(posedge clk); #1;
    src_q.push_back(w);
  endtask

  task automatic out_beat(input bit v, input logic [LW-1:0] b);
    @(posedge clk); #1;
    proc_out_valid = v;
    proc_out_byte  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) out_beat(1'b0, 8'hEE);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(proc_valid == 0, "R1 reset strobe", proc_valid, 0);
    check(pack_valid == 0, "R1 reset pulse", pack_valid, 0);
    check(pack_data == '0, "R1 reset data", pack_data, 0);
    check(proc_byte == '0, "R1 reset byte", proc_byte, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(proc_valid == 0 && pack_valid == 0, "R1 after release", {proc_valid, pack_valid}, 0);

    // R3/R5: three words back to back, gapless stream
    push_word(40'h55_44_33_22_11);
    push_word(40'hA5_96_87_78_69);
    push_word(40'h0F_1E_2D_3C_4B);
    idle(20);

    // R4: a lone word after an idle stretch
    push_word(40'hFE_DC_BA_98_76);
    idle(12);

    // R6/R7/R8: two contiguous groups, distinct discarded bytes
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 5; i++) out_beat(1'b1, 8'(8'h10 * (g + 1) + i + 1));
    idle(4);

    // R9: groups with gaps and junk on invalid cycles
    for (int i = 0; i < 10; i++) begin
      out_beat(1'b1, 8'(8'hC0 + i));
      idle(i % 3);
    end
    idle(4);
    check(packs_seen == 4, "R9 result count", packs_seen, 4);

    // both sides at once
    push_word(40'h13_57_9B_DF_02);
    for (int i = 0; i < 5; i++) out_beat(1'b1, 8'(8'h80 + i));
    idle(8);

    // R10: reset in the middle of a word and of a group
    push_word(40'hDE_AD_BE_EF_42);
    idle(2);
    out_beat(1'b1, 8'h99);
    out_beat(1'b1, 8'h98);
    @(posedge clk); #1;
    proc_out_valid = 1'b0;
    rst_n = 1'b0;
    idle(2);
    @(posedge clk); #1 rst_n = 1'b1;
    push_word(40'h66_77_88_99_AA);
    out_beat(1'b1, 8'h31);
    out_beat(1'b1, 8'h32);
    out_beat(1'b1, 8'h33);
    out_beat(1'b1, 8'h34);
    out_beat(1'b1, 8'h35);
    idle(8);
    @(negedge clk);
    check(pack_data == 24'h33_32_31, "R10 fresh group after reset", pack_data, 24'h333231);
    check(packs_seen == 6, "R10 no stale result", packs_seen, 6);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule